// File: doc/BRIEF.md
# Bytewide Nonvolatile RAM Device Controller

This block is the device-side logic of a byte-wide nonvolatile memory that presents an asynchronous SRAM-style pin interface. The active-low select, write strobe and output enable, the address and the input data are sampled on a fast internal clock. Each pin passes through a two-flop synchronizer before the controller looks at it. The storage is a small array of rows, each holding eight bytes. The upper address bits pick a row and the lower three bits pick a byte within it.

Lowering the select opens a row and starts a timed access. Moving only the column bits while selected gives a fast page access. Moving the row bits while selected makes the controller close the row, wait out a precharge and reopen the row on its own. A write is select-controlled when the write strobe is already low as the access begins. Otherwise the access starts as a read and turns into a write when the strobe falls. The output data bus is a data vector with a separate drive-enable output, which stands for the tri-state buffer. The enable is held off until the access time has passed, even when output enable is already low.

Top module: `nvs_ctrl`

## Requirements
- R1: After reset the output drive enable is low and the controller is deselected, with no access open.
- R2: An access begins when the select is seen low, and the whole address is latched at that point. The byte stored at that address is then presented once the access completes.
- R3: The output stays undriven for at least T_ACC internal cycles after an access begins, even when output enable is already low.
- R4: Raising the select closes the row, releases the output and starts a precharge of T_PRE cycles. If the select falls again during the precharge, the new access waits until the precharge ends.
- R5: A change of the row bits (address above bit 2) while selected starts a precharge by itself. The row is then reopened at the new address and its byte is presented after the precharge and a full access.
- R6: A change of only the column bits (address bits 2..0) while selected and not writing is a page access. It presents the new byte within T_PAGE cycles, with no precharge.
- R7: A strobe-controlled write latches the column when the write strobe falls and stores the bus data when it rises.
- R8: A select-controlled write has the strobe low as the access begins. It stores the bus data at whichever rises first, the select or the strobe.
- R9: Each write stores exactly one byte. Data placed on the bus after the capturing edge is not stored.
- R10: Within one selection, repeated strobe pulses each write their own column of the open row (page write).
- R11: While the write strobe is low, the output is undriven regardless of output enable.
- R12: While output enable is high, the output is undriven. Lowering it again drives the valid byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ROW_W+COL_W | Byte address; the upper bits give the row, the low COL_W bits give the column |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data toward the bus |
| dout_en | output | 1 | Bus drive enable (high means the bus is driven) |

## Verification
A pin change reaches the controller two cycles after it is applied, because of the synchronizers. The controller's state moves on the third cycle, and the drive enable is registered from that next state. A full read is therefore due about T_ACC+3 cycles after the select falls. A page byte is due about T_PAGE+3 cycles after a column change, and a row change costs a further T_PRE cycles. The bench checks for an undriven bus inside the windows where data must still be withheld. It samples data only after the due cycle plus a small margin, and on the falling clock edge. The page check comes well before a precharge could have completed, so it separates a page access from a row reopen.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_ACC  = 2'd2,
        ST_OPEN = 2'd3
    } nvs_state_e;
endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
    parameter int             W   = 1,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST;
            s2_q <= RST;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int ROW_W = 4,
    parameter int COL_W = 3,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    localparam int ROWS = 1 << ROW_W;
    localparam int COLS = 1 << COL_W;

    logic [COLS-1:0][DW-1:0] row_view [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        logic [COLS-1:0][DW-1:0] cells_q;
        logic                    hit;
        assign hit = wr_en && (row == ROW_W'(g));
        always_ff @(posedge clk) begin
            if (hit) cells_q[col] <= wdata;
        end
        assign row_view[g] = cells_q;
    end

    assign rdata = row_view[row][col];
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 3,
    parameter int T_ACC  = 6,
    parameter int T_PRE  = 5,
    parameter int T_PAGE = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ce_s,
    input  logic                   we_s,
    input  logic                   oe_s,
    input  logic [ROW_W+COL_W-1:0] addr_s,
    input  logic [7:0]             din_s,
    input  logic [7:0]             rd_data,
    output logic                   mem_we,
    output logic [ROW_W-1:0]       mem_row,
    output logic [COL_W-1:0]       mem_col,
    output logic [7:0]             mem_wdata,
    output logic [7:0]             dout,
    output logic                   dout_en,
    output nvs_state_e             state
);
    localparam int AW   = ROW_W + COL_W;
    localparam int TM1  = (T_ACC > T_PRE) ? T_ACC : T_PRE;
    localparam int TMAX = (TM1 > T_PAGE) ? TM1 : T_PAGE;
    localparam int CW   = $clog2(TMAX + 1);

    typedef struct packed {
        nvs_state_e       st;
        logic [CW-1:0]    cnt;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             wr_pend;
        logic             we_p;
        logic [7:0]       dout;
        logic             drive;
    } seq_t;

    seq_t r_q, r_d;

    logic             we_fall, we_rise, up_chg, col_chg, start;
    logic [ROW_W-1:0] a_row;
    logic [COL_W-1:0] a_col;

    assign a_row   = addr_s[AW-1:COL_W];
    assign a_col   = addr_s[COL_W-1:0];
    assign we_fall = r_q.we_p && !we_s;
    assign we_rise = !r_q.we_p && we_s;
    assign up_chg  = (a_row != r_q.row);
    assign col_chg = (a_col != r_q.col);

    always_comb begin
        r_d       = r_q;
        mem_we    = 1'b0;
        start     = 1'b0;
        r_d.we_p  = we_s;
        unique case (r_q.st)
            ST_IDLE: begin
                if (!ce_s) start = 1'b1;
            end
            ST_PRE: begin
                if (r_q.cnt <= CW'(1)) begin
                    if (!ce_s) start = 1'b1;
                    else begin
                        r_d.st  = ST_IDLE;
                        r_d.cnt = '0;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            ST_ACC, ST_OPEN: begin
                // a pending write ends at the first of strobe rise, deselect or row move
                if (r_q.wr_pend && (ce_s || we_rise || up_chg)) begin
                    mem_we      = 1'b1;
                    r_d.wr_pend = 1'b0;
                end
                if (ce_s || up_chg) begin
                    r_d.st  = ST_PRE;
                    r_d.cnt = CW'(T_PRE);
                end else if (we_fall && !r_q.wr_pend) begin
                    r_d.col     = a_col;
                    r_d.wr_pend = 1'b1;
                end else if (!r_q.wr_pend && we_s && col_chg) begin
                    r_d.col = a_col;
                    if (r_q.st == ST_OPEN) r_d.cnt = CW'(T_PAGE);
                end else if (r_q.st == ST_ACC) begin
                    if (r_q.cnt <= CW'(1)) begin
                        r_d.st  = ST_OPEN;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt - CW'(1);
                    end
                end else if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (start) begin
            r_d.st      = ST_ACC;
            r_d.cnt     = CW'(T_ACC);
            r_d.row     = a_row;
            r_d.col     = a_col;
            r_d.wr_pend = !we_s;
        end
        r_d.dout  = rd_data;
        r_d.drive = (r_d.st == ST_OPEN) && (r_d.cnt == '0) && !r_d.wr_pend
                    && !ce_s && we_s && !oe_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.cnt     <= '0;
            r_q.row     <= '0;
            r_q.col     <= '0;
            r_q.wr_pend <= 1'b0;
            r_q.we_p    <= 1'b1;
            r_q.dout    <= '0;
            r_q.drive   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_row   = r_q.row;
    assign mem_col   = r_q.col;
    assign mem_wdata = din_s;
    assign dout      = r_q.dout;
    assign dout_en   = r_q.drive;
    assign state     = r_q.st;
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
    import nvs_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 3,
    parameter int T_ACC  = 6,
    parameter int T_PRE  = 5,
    parameter int T_PAGE = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ce_n,
    input  logic                   we_n,
    input  logic                   oe_n,
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic [7:0]             din,
    output logic [7:0]             dout,
    output logic                   dout_en
);
    localparam int AW = ROW_W + COL_W;
    localparam int DSW = AW + 8;

    logic [2:0]       ctl_s;
    logic [DSW-1:0]   dat_s;
    logic             mem_we;
    logic [ROW_W-1:0] mem_row;
    logic [COL_W-1:0] mem_col;
    logic [7:0]       mem_wdata, rd_data;
    nvs_state_e       seq_state;

    nvs_sync #(.W(3), .RST(3'b111)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d({ce_n, we_n, oe_n}), .q(ctl_s)
    );

    nvs_sync #(.W(DSW), .RST('0)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(dat_s)
    );

    nvs_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .T_ACC(T_ACC), .T_PRE(T_PRE), .T_PAGE(T_PAGE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ce_s(ctl_s[2]), .we_s(ctl_s[1]), .oe_s(ctl_s[0]),
        .addr_s(dat_s[DSW-1:8]), .din_s(dat_s[7:0]),
        .rd_data(rd_data),
        .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col), .mem_wdata(mem_wdata),
        .dout(dout), .dout_en(dout_en), .state(seq_state)
    );

    nvs_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(8)) u_array (
        .clk(clk), .wr_en(mem_we), .row(mem_row), .col(mem_col),
        .wdata(mem_wdata), .rdata(rd_data)
    );
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk
    import nvs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       dout_en,
    input logic       mem_we,
    input nvs_state_e state
);
    // R11: strobe low long enough to cross the synchronizer forces high impedance
    p_we_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && !$past(we_n) && !$past(we_n, 2) && !$past(we_n, 3)) |-> !dout_en);

    // R12: output enable high forces high impedance
    p_oe_hiz_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && $past(oe_n) && $past(oe_n, 2) && $past(oe_n, 3)) |-> !dout_en);

    // R4: a deselected device never drives
    p_desel_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && $past(ce_n) && $past(ce_n, 2) && $past(ce_n, 3)) |-> !dout_en);

    // R3: no drive while the access timer runs
    p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACC) |-> !dout_en);

    // R5: no drive during precharge
    p_pre_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE) |-> !dout_en);

    // R7: array writes happen only inside an open access
    p_wr_in_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == ST_ACC || state == ST_OPEN));

    // R2: a row is only reached through a timed access
    p_open_via_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && $past(state) != ST_OPEN) |-> $past(state) == ST_ACC);
endmodule

bind nvs_ctrl nvs_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .dout_en(dout_en), .mem_we(mem_we), .state(seq_state)
);

// File: tb/nvs_ctrl_test.sv
module nvs_ctrl_test;
    localparam int ROW_W = 4;
    localparam int COL_W = 3;
    localparam int AW    = ROW_W + COL_W;

    logic          clk = 1'b0;
    logic          rst_n, ce_n, we_n, oe_n;
    logic [AW-1:0] addr;
    logic [7:0]    din;
    logic [7:0]    dout;
    logic          dout_en;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    nvs_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .T_ACC(6), .T_PRE(5), .T_PAGE(2)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t sb[$];
    event smp;

    function automatic logic [AW-1:0] mk(int row, int col);
        return {ROW_W'(row), COL_W'(col)};
    endfunction

    function automatic logic [7:0] pg(int c);
        return 8'(8'h40 + c * 7);
    endfunction

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_byte(logic [7:0] v, string req);
        exp_t e;
        e.val = v;
        e.req = req;
        sb.push_back(e);
        ->smp;
        #1;
    endtask

    task automatic check_hiz(string req);
        checks++;
        if (dout_en !== 1'b0) begin
            errors++;
            $display("FAIL %s: dout_en=%0b expected 0", req, dout_en);
        end
    endtask

    // monitor: compare every queued expectation against the bus
    initial begin
        forever begin
            @(smp);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (dout_en !== 1'b1 || dout !== e.val) begin
                    errors++;
                    $display("FAIL %s: dout_en=%0b dout=%02h expected driven %02h",
                             e.req, dout_en, dout, e.val);
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        check_hiz("R1");

        // R8: select-controlled write, strobe already low
        addr = mk(0, 5); din = 8'hA5; we_n = 1'b0;
        cyc(1);
        ce_n = 1'b0;
        cyc(10);
        ce_n = 1'b1;
        cyc(3);
        we_n = 1'b1; din = 8'h00;
        cyc(10);

        // R2 / R3: read, output enable low from the start
        oe_n = 1'b0; addr = mk(0, 5); ce_n = 1'b0;
        cyc(4);
        check_hiz("R3");
        cyc(16);
        expect_byte(8'hA5, "R8");

        // R7 / R11: strobe-controlled write in the open row
        addr = mk(0, 2);
        cyc(6);
        we_n = 1'b0; din = 8'h3C;
        cyc(4);
        check_hiz("R11");
        cyc(2);
        we_n = 1'b1;
        cyc(1);
        din = 8'hC3;
        cyc(5);
        expect_byte(8'h3C, "R7");
        ce_n = 1'b1;
        cyc(10);

        // R10: page write of all eight columns of row 2
        ce_n = 1'b0; addr = mk(2, 0);
        cyc(14);
        for (int c = 0; c < 8; c++) begin
            addr = mk(2, c);
            cyc(2);
            din = pg(c); we_n = 1'b0;
            cyc(3);
            we_n = 1'b1;
            cyc(3);
        end
        ce_n = 1'b1;
        cyc(10);

        // R10 / R6: read back with page accesses in reverse order
        ce_n = 1'b0; addr = mk(2, 0);
        cyc(20);
        expect_byte(pg(0), "R10");
        for (int c = 7; c >= 1; c--) begin
            addr = mk(2, c);
            cyc(6);
            expect_byte(pg(c), "R6");
        end

        // R5: row change while selected
        addr = mk(0, 5);
        cyc(4);
        check_hiz("R5");
        cyc(20);
        expect_byte(8'hA5, "R5");
        addr = mk(0, 2);
        cyc(6);
        expect_byte(8'h3C, "R9");

        // R12: output enable gating
        oe_n = 1'b1;
        cyc(4);
        check_hiz("R12");
        oe_n = 1'b0;
        cyc(4);
        expect_byte(8'h3C, "R12");

        // R4: select dropped briefly, access held off by precharge
        ce_n = 1'b1;
        cyc(2);
        addr = mk(2, 7); ce_n = 1'b0;
        cyc(9);
        check_hiz("R4");
        cyc(12);
        expect_byte(pg(7), "R4");
        ce_n = 1'b1;
        cyc(5);
        check_hiz("R4");

        cyc(5);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule